// File: doc/BRIEF.md
# Binary32 Product Renormalizer

This block multiplies the significands of two binary32 operands and returns the exact product as a left-justified 48-bit significand. The product exponent is rebiased for binary64. Either operand may be subnormal. Every finite binary32 product, down to the square of the smallest subnormal, fits the normal binary64 range, so the output never needs subnormal handling. It is the front end of a fused multiply-add whose addend and result are binary64. An alignment and addition stage downstream takes its outputs.

The leading zeros of each 24-bit input significand are counted in parallel with the multiplier. The sum of the two counts drives a barrel shifter on the raw product. This puts the product's leading one at bit 47 or bit 46. A final one-position step moves it to bit 47 and takes one off the exponent. Product normalization costs one shifter on the multiplier output and no normalizers on the inputs. The results are held in an output register. A parameter can remove that register to make the block purely combinational.

An exponent field of all ones is not decoded as infinity or NaN. It is treated as an ordinary exponent value, and special operands are resolved by the neighbouring logic.

Top module: `prod_renorm`

## Requirements
- R1: `sign_o` is the XOR of bit 31 of both operands, including when the product is zero (for example -0 times +5 gives `sign_o` = 1).
- R2: For a nonzero product, bit 47 of `man_o` is 1. `man_o` equals the integer product of the two 24-bit significands, shifted left until bit 47 is set. A significand is {hidden bit, bits 22:0}, and the hidden bit is 1 unless the exponent field (bits 30:23) is zero.
- R3: For a nonzero product, the exact product value equals (`man_o` / 2^47) * 2^(`exp_o` - 1023). For example, 1.0 times 1.0 gives `exp_o` = 1023 and 1.5 times 1.5 gives `exp_o` = 1024.
- R4: An operand whose exponent field is zero has hidden bit 0 and effective field value 1, so its value is fraction * 2^-149. For example, 2^-127 times 2.0 gives `exp_o` = 897 and `man_o` = 2^47.
- R5: Squaring the smallest subnormal (0x00000001) gives `exp_o` = 725 and `man_o` = 2^47.
- R6: A nonzero result always has `exp_o` between 725 and 1278, inclusive. Squaring 0x7F7FFFFF gives `exp_o` = 1278.
- R7: If either operand has exponent and fraction fields both zero, `zero_o` is 1 and `man_o` and `exp_o` are 0. Otherwise `zero_o` is 0.
- R8: With the output register present, the outputs show the operands sampled at the previous rising clock edge. While `rst_ni` is low, the outputs are `zero_o` = 1 and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First binary32 operand |
| b_i | input | 32 | Second binary32 operand |
| sign_o | output | 1 | Product sign |
| exp_o | output | 11 | Product exponent, biased by 1023 |
| man_o | output | 48 | Normalized product significand, leading one at bit 47 |
| zero_o | output | 1 | Product is zero |

## Verification
The hardest case to reach is the deepest shift. Both significands must carry many leading zeros, and the raw product's leading one must land at bit 46, so the shifter runs its full distance and the final one-bit step also fires. Directed vectors square the smallest subnormal and multiply subnormals by normals and by each other. A random mix, in which a quarter of the operands have a zero exponent field and random fractions, covers the intermediate counts. Every output word is compared with an integer model that finds the product's top bit by a scan, without counting leading zeros per operand.

// File: rtl/prod_renorm_pkg.sv
package prod_renorm_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;

  function automatic int fmt_bias(input int ew);
    return (1 << (ew - 1)) - 1;
  endfunction
endpackage

// File: rtl/pr_lzc.sv
module pr_lzc #(
  parameter int W  = 24,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++)
      if (d_i[i]) cnt_o = CW'(W - 1 - i);
    zero_o = (d_i == '0);
  end
endmodule

// File: rtl/pr_mul.sv
module pr_mul #(
  parameter int W = 24
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  assign p_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
endmodule

// File: rtl/pr_lshift.sv
module pr_lshift #(
  parameter int W  = 48,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] stg [SW+1];
  assign stg[0] = d_i;
  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stg[k+1] = amt_i[k] ? (stg[k] << (1 << k)) : stg[k];
  end
  assign q_o = stg[SW];
endmodule

// File: rtl/prod_renorm.sv
module prod_renorm #(
  parameter int EXP_W   = prod_renorm_pkg::SP_EXP_W,
  parameter int FRAC_W  = prod_renorm_pkg::SP_FRAC_W,
  parameter int OEXP_W  = prod_renorm_pkg::DP_EXP_W,
  parameter bit OUT_REG = 1'b1,
  localparam int IW = 1 + EXP_W + FRAC_W,
  localparam int PW = 2 * (FRAC_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IW-1:0]     a_i,
  input  logic [IW-1:0]     b_i,
  output logic              sign_o,
  output logic [OEXP_W-1:0] exp_o,
  output logic [PW-1:0]     man_o,
  output logic              zero_o
);
  localparam int P       = FRAC_W + 1;
  localparam int CW      = $clog2(P + 1);
  localparam int SW      = $clog2(PW);
  localparam int IBIAS   = prod_renorm_pkg::fmt_bias(EXP_W);
  localparam int OBIAS   = prod_renorm_pkg::fmt_bias(OEXP_W);
  localparam int EXP_OFS = OBIAS + 1 - 2 * IBIAS;

  logic [EXP_W-1:0]  ef_a, ef_b, eff_a, eff_b;
  logic              nz_a, nz_b;
  logic [P-1:0]      sig_a, sig_b;
  logic [CW-1:0]     lz_a, lz_b;
  logic              za, zb;
  logic [PW-1:0]     prod, sh, norm;
  logic [SW-1:0]     lz_sum;
  logic              fix;
  logic [OEXP_W-1:0] exp_calc;

  logic              sign_c, zero_c;
  logic [OEXP_W-1:0] exp_c;
  logic [PW-1:0]     man_c;

  assign ef_a  = a_i[IW-2:FRAC_W];
  assign ef_b  = b_i[IW-2:FRAC_W];
  assign nz_a  = |ef_a;
  assign nz_b  = |ef_b;
  assign sig_a = {nz_a, a_i[FRAC_W-1:0]};
  assign sig_b = {nz_b, b_i[FRAC_W-1:0]};
  // subnormal fields behave as the minimum normal exponent
  assign eff_a = nz_a ? ef_a : EXP_W'(1);
  assign eff_b = nz_b ? ef_b : EXP_W'(1);

  pr_lzc #(.W(P), .CW(CW)) u_lzc_a (.d_i(sig_a), .cnt_o(lz_a), .zero_o(za));
  pr_lzc #(.W(P), .CW(CW)) u_lzc_b (.d_i(sig_b), .cnt_o(lz_b), .zero_o(zb));
  pr_mul #(.W(P)) u_mul (.a_i(sig_a), .b_i(sig_b), .p_o(prod));

  assign lz_sum = SW'(lz_a) + SW'(lz_b);
  pr_lshift #(.W(PW), .SW(SW)) u_shift (.d_i(prod), .amt_i(lz_sum), .q_o(sh));

  // leading one now sits at PW-1 or PW-2
  assign fix  = ~sh[PW-1];
  assign norm = fix ? {sh[PW-2:0], 1'b0} : sh;

  // modular arithmetic: the true result always fits OEXP_W bits
  assign exp_calc = OEXP_W'(eff_a) + OEXP_W'(eff_b) + OEXP_W'(EXP_OFS)
                  - OEXP_W'(lz_sum) - OEXP_W'(fix);

  assign sign_c = a_i[IW-1] ^ b_i[IW-1];
  assign zero_c = za | zb;
  assign exp_c  = zero_c ? '0 : exp_calc;
  assign man_c  = zero_c ? '0 : norm;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sign_o <= 1'b0;
        exp_o  <= '0;
        man_o  <= '0;
        zero_o <= 1'b1;
      end else begin
        sign_o <= sign_c;
        exp_o  <= exp_c;
        man_o  <= man_c;
        zero_o <= zero_c;
      end
    end
  end else begin : g_comb
    assign sign_o = sign_c;
    assign exp_o  = exp_c;
    assign man_o  = man_c;
    assign zero_o = zero_c;
  end
endmodule

// File: rtl/prod_renorm_chk.sv
module prod_renorm_chk #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int OEXP_W  = 11,
  parameter bit OUT_REG = 1'b1,
  localparam int IW = 1 + EXP_W + FRAC_W,
  localparam int PW = 2 * (FRAC_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IW-1:0]     a_i,
  input logic [IW-1:0]     b_i,
  input logic              sign_o,
  input logic [OEXP_W-1:0] exp_o,
  input logic [PW-1:0]     man_o,
  input logic              zero_o
);
  localparam int IBIAS = (1 << (EXP_W - 1)) - 1;
  localparam int OBIAS = (1 << (OEXP_W - 1)) - 1;
  localparam int EMIN  = OBIAS + 2 * (1 - IBIAS - FRAC_W);
  localparam int EMAX  = OBIAS + 2 * IBIAS + 1;

  assert_lead_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_o |-> man_o[PW-1]);

  assert_exp_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_o |-> (int'(exp_o) >= EMIN && int'(exp_o) <= EMAX));

  assert_zero_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (man_o == '0 && exp_o == '0));

  if (OUT_REG) begin : g_seq
    assert_sign_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (sign_o == ($past(a_i[IW-1]) ^ $past(b_i[IW-1]))));

    assert_zero_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i[IW-2:0] == '0 || b_i[IW-2:0] == '0) |=> zero_o);

    assert_zero_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i[IW-2:0] != '0 && b_i[IW-2:0] != '0) |=> !zero_o);
  end
endmodule

bind prod_renorm prod_renorm_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OEXP_W(OEXP_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
  .sign_o(sign_o), .exp_o(exp_o), .man_o(man_o), .zero_o(zero_o)
);

// File: tb/prod_renorm_bench.sv
`timescale 1ns/1ps
module prod_renorm_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        sign_o, zero_o;
  logic [10:0] exp_o;
  logic [47:0] man_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [60:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  prod_renorm u_prod_renorm (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .sign_o(sign_o), .exp_o(exp_o), .man_o(man_o), .zero_o(zero_o)
  );

  // packed as {sign, exp[10:0], man[47:0], zero}
  function automatic logic [60:0] model(input logic [31:0] a, input logic [31:0] b);
    longint unsigned sa, sb, p;
    int ea, eb, msb;
    logic s;
    s  = a[31] ^ b[31];
    sa = 64'(a[22:0]);
    sb = 64'(b[22:0]);
    if (a[30:23] != 0) sa += 64'd1 << 23;
    if (b[30:23] != 0) sb += 64'd1 << 23;
    ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
    eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
    p  = sa * sb;
    if (p == 0) return {s, 11'd0, 48'd0, 1'b1};
    msb = 0;
    for (int i = 0; i < 48; i++) if (p[i]) msb = i;
    return {s, 11'(ea + eb - 254 - 46 + msb + 1023), 48'(p << (47 - msb)), 1'b0};
  endfunction

  task automatic check_front();
    logic [60:0] e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    n_tests++;
    if ({sign_o, exp_o, man_o, zero_o} !== e) begin
      n_fail++;
      $display("FAIL %s: got s=%0b e=%0d m=%h z=%0b exp s=%0b e=%0d m=%h z=%0b",
               t, sign_o, exp_o, man_o, zero_o, e[60], e[59:49], e[48:1], e[0]);
    end
    if (!zero_o) begin
      n_tests++;
      if (exp_o < 11'd725 || exp_o > 11'd1278) begin
        n_fail++;
        $display("FAIL R6: got e=%0d exp range 725..1278", exp_o);
      end
    end
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    check_front();
    a_i = a;
    b_i = b;
    exp_q.push_back(model(a, b));
    tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] rnd_op();
    logic [7:0] e;
    e = ($urandom % 4 == 0) ? 8'd0 : 8'(1 + $urandom % 254);
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    #500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    a_i = 32'h3f800000;
    b_i = 32'h3f800000;
    repeat (3) @(negedge clk);
    // R8: reset state holds even with live operands
    n_tests++;
    if ({sign_o, exp_o, man_o, zero_o} !== {1'b0, 11'd0, 48'd0, 1'b1}) begin
      n_fail++;
      $display("FAIL R8: got s=%0b e=%0d m=%h z=%0b exp reset state",
               sign_o, exp_o, man_o, zero_o);
    end
    a_i = '0;
    b_i = '0;
    rst_ni = 1'b1;

    step(32'h3f800000, 32'h3f800000, "R3");
    step(32'h3fc00000, 32'h3fc00000, "R3");
    step(32'h00000001, 32'h00000001, "R5");
    step(32'h7f7fffff, 32'h7f7fffff, "R6");
    step(32'h00400000, 32'h40000000, "R4");
    step(32'h007fffff, 32'h00000003, "R4");
    step(32'h00000001, 32'h7f7fffff, "R4");
    step(32'h00000000, 32'h40a00000, "R7");
    step(32'h80000000, 32'h40a00000, "R1");
    step(32'h40a00000, 32'h80000000, "R7");
    step(32'h00000000, 32'h00000000, "R7");
    step(32'hc0400000, 32'h3f800000, "R1");
    step(32'hc0400000, 32'hbfc00000, "R1");
    step(32'h3f800001, 32'h00000005, "R8");
    step(32'h00123456, 32'h80654321, "R2");
    for (int i = 0; i < 400; i++) step(rnd_op(), rnd_op(), "R2");
    step(32'h0, 32'h0, "R7");
    @(negedge clk);
    check_front();
    finish_run();
  end
endmodule